// File: doc/BRIEF.md
# ADC Start Arbiter and Successive-Approximation Sequencer

This block runs one 12-bit analog-to-digital conversion for each start it accepts. A start can come from three places:

- a software strobe, which is always honoured;
- a timer overflow pulse, honoured only while its enable is high;
- an asynchronous external trigger, which is synchronized by two flops and acts only on its falling edge while its enable is high.

After accepting a start, the block waits a fixed settling time so that the input multiplexer and the sample-and-hold can settle. It then raises the hold signal and carries out a successive-approximation search. The search works one bit per step, starting at the most significant bit. Each step presents a trial code to an external comparator and reads back whether the analog input is at or above that trial level.

When the least significant bit has been decided, the block registers the result in offset binary, where 0x800 is zero volts. It marks the result with a one-cycle end-of-conversion strobe. The block does not queue a start that arrives while a conversion is running. It reports such a start with a one-cycle error pulse and lets the running conversion finish unchanged. The settle and step durations are set in nanoseconds and converted to clock cycles from the clock-frequency parameter. At the default values the whole conversion takes about 22 µs.

Top module: `sar_conv_seq`

## Requirements
- R1: A high `sw_start` sampled at a clock edge while idle starts a conversion, and `busy` is high from the cycle after that edge until the result is delivered.
- R2: A high `tmr_ovf` starts a conversion only when `tmr_en` is high at the same edge; with `tmr_en` low it has no effect.
- R3: `ext_trig_n` starts a conversion only on a high-to-low transition while `ext_en` is high; the start is accepted at the third rising edge after the pin falls (two synchronizer flops plus edge detection); a rising edge, or a falling edge while `ext_en` is low, has no effect.
- R4: `hold` and `trial_code` stay 0 for SETTLE_CYC cycles after the start edge; then `hold` rises and the first trial code is 0x800 (only the MSB set).
- R5: Each of the 12 bits takes STEP_CYC cycles, MSB first; a bit is kept when `cmp_ge` is 1 at the end of its step and cleared otherwise, so `result` equals the largest code whose trial level the input meets (offset binary, 0x800 = zero volts).
- R6: `eoc` is a single-cycle pulse, seen in the cycle that follows SETTLE_CYC + 12*STEP_CYC edges after the start edge, with `busy` and `hold` low in that cycle.
- R7: A start from any enabled source that arrives while busy raises `start_err` for exactly one cycle, the cycle after that edge; it is otherwise ignored, and the running conversion ends at its original time with its original result. No error is raised for a start accepted while idle.
- R8: `result` changes only in the cycle where `eoc` is high and holds its value until the next `eoc`.
- R9: After reset, `busy`, `hold`, `eoc`, `start_err`, `trial_code` and `result` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_start | input | 1 | Software start strobe |
| tmr_ovf | input | 1 | Timer overflow pulse |
| tmr_en | input | 1 | Enables timer-overflow starts |
| ext_trig_n | input | 1 | Asynchronous external trigger, active on falling edge |
| ext_en | input | 1 | Enables external starts |
| cmp_ge | input | 1 | Comparator: analog input is at or above the trial level |
| trial_code | output | 12 | Trial code driven to the comparator DAC |
| hold | output | 1 | Sample-and-hold in hold, high during the search |
| busy | output | 1 | Conversion in progress |
| result | output | 12 | Last conversion result, offset binary |
| eoc | output | 1 | One-cycle end-of-conversion strobe |
| start_err | output | 1 | One-cycle pulse for a start received while busy |

## Verification
The bench keeps the 200 MHz clock parameter but sets the settle time to 40 ns and the step time to 20 ns. That gives 8 settle cycles and 4 cycles per bit, so a full conversion takes 56 cycles. These short windows let the bench count every cycle from the start edge to `eoc`. They also let it place colliding starts inside the settle phase and inside the search. Within these windows it can check the exact latency, the hold timing, the first trial code and the decided result for all three start sources and for full-scale, zero-volt and single-LSB inputs.

// File: rtl/sar_conv_pkg.sv
package sar_conv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_CONV   = 2'd2
  } seq_state_t;

  // Converts a duration in ns to whole clock cycles, never below one cycle.
  function automatic int unsigned ns_to_cyc(input longint unsigned hz,
                                            input longint unsigned ns);
    longint unsigned c;
    c = (hz * ns) / 64'd1_000_000_000;
    if (c == 0) c = 1;
    return c[31:0];
  endfunction

endpackage

// File: rtl/sar_start_merge.sv
module sar_start_merge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sw_start,
  input  logic tmr_ovf,
  input  logic tmr_en,
  input  logic ext_trig_n,
  input  logic ext_en,
  output logic start_req
);

  // chain[0..SYNC_STAGES-1] synchronize, chain[SYNC_STAGES] is the delayed copy
  logic [SYNC_STAGES:0] chain;
  logic                 ext_fall;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[SYNC_STAGES-1:0], ext_trig_n};
  end

  assign ext_fall  = chain[SYNC_STAGES] & ~chain[SYNC_STAGES-1];
  assign start_req = sw_start | (tmr_ovf & tmr_en) | (ext_fall & ext_en);

  // R3: an external edge with its enable low never produces a start
  p_ext_gated_r3: assert property (@(posedge clk) disable iff (rst)
    (!ext_en && !sw_start && !(tmr_ovf && tmr_en)) |-> !start_req);

  // R2: timer pulse alone with its enable low never produces a start
  p_tmr_gated_r2: assert property (@(posedge clk) disable iff (rst)
    (!tmr_en && !sw_start && !ext_en) |-> !start_req);

endmodule

// File: rtl/sar_seq_engine.sv
module sar_seq_engine
  import sar_conv_pkg::*;
#(
  parameter int unsigned NBITS      = 12,
  parameter int unsigned SETTLE_CYC = 2000,
  parameter int unsigned STEP_CYC   = 200
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_req,
  input  logic             cmp_ge,
  output logic [NBITS-1:0] trial_code,
  output logic             hold,
  output logic             busy,
  output logic [NBITS-1:0] result,
  output logic             eoc,
  output logic             start_err
);

  localparam int unsigned MAXC = (SETTLE_CYC > STEP_CYC) ? SETTLE_CYC : STEP_CYC;
  localparam int unsigned CW   = $clog2(MAXC + 1);
  localparam int unsigned IW   = $clog2(NBITS);
  localparam logic [NBITS-1:0] MSB_ONE = {1'b1, {(NBITS-1){1'b0}}};
  localparam logic [CW-1:0]    SETTLE_LD = CW'(SETTLE_CYC - 1);
  localparam logic [CW-1:0]    STEP_LD   = CW'(STEP_CYC - 1);
  localparam logic [IW-1:0]    TOP_IDX   = IW'(NBITS - 1);

  seq_state_t       state;
  logic [CW-1:0]    cnt;
  logic [IW-1:0]    bidx;
  logic [NBITS-1:0] sar;
  logic [NBITS-1:0] decided;
  logic [NBITS-1:0] advanced;

  // Decide the current bit, then arm the next lower one
  always_comb begin
    decided       = sar;
    decided[bidx] = cmp_ge;
    advanced      = decided;
    if (bidx != '0) advanced[bidx - 1'b1] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      bidx      <= '0;
      sar       <= '0;
      result    <= '0;
      eoc       <= 1'b0;
      start_err <= 1'b0;
    end else begin
      eoc       <= 1'b0;
      start_err <= start_req && (state != ST_IDLE);
      case (state)
        ST_IDLE: begin
          if (start_req) begin
            state <= ST_SETTLE;
            cnt   <= SETTLE_LD;
          end
        end
        ST_SETTLE: begin
          if (cnt == '0) begin
            state <= ST_CONV;
            cnt   <= STEP_LD;
            bidx  <= TOP_IDX;
            sar   <= MSB_ONE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_CONV: begin
          if (cnt == '0) begin
            if (bidx == '0) begin
              result <= decided;
              eoc    <= 1'b1;
              sar    <= '0;
              state  <= ST_IDLE;
            end else begin
              sar  <= advanced;
              bidx <= bidx - 1'b1;
              cnt  <= STEP_LD;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign trial_code = sar;
  assign hold       = (state == ST_CONV);
  assign busy       = (state != ST_IDLE);

  // R1: an accepted start makes the block busy on the next cycle
  p_start_busy_r1: assert property (@(posedge clk) disable iff (rst)
    (!busy && start_req) |=> busy);

  // R4: the search opens with only the MSB set
  p_first_trial_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(hold) |-> (trial_code == MSB_ONE));

  // R4: hold only during a conversion
  p_hold_busy_r4: assert property (@(posedge clk) disable iff (rst)
    hold |-> busy);

  // R6: single-cycle strobe, delivered while idle
  p_eoc_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    eoc |=> !eoc);
  p_eoc_idle_r6: assert property (@(posedge clk) disable iff (rst)
    eoc |-> (!busy && !hold));

  // R7: an error pulse follows a cycle spent busy
  p_err_busy_r7: assert property (@(posedge clk) disable iff (rst)
    start_err |-> $past(busy));

  // R8: result moves only together with the strobe
  p_result_stable_r8: assert property (@(posedge clk) disable iff (rst)
    !eoc |-> $stable(result));

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_conv_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 200_000_000,
  parameter int unsigned SETTLE_NS = 10_000,
  parameter int unsigned STEP_NS   = 1_000,
  parameter int unsigned NBITS     = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_start,
  input  logic             tmr_ovf,
  input  logic             tmr_en,
  input  logic             ext_trig_n,
  input  logic             ext_en,
  input  logic             cmp_ge,
  output logic [NBITS-1:0] trial_code,
  output logic             hold,
  output logic             busy,
  output logic [NBITS-1:0] result,
  output logic             eoc,
  output logic             start_err
);

  localparam int unsigned SETTLE_CYC = ns_to_cyc(64'(CLK_HZ), 64'(SETTLE_NS));
  localparam int unsigned STEP_CYC   = ns_to_cyc(64'(CLK_HZ), 64'(STEP_NS));

  logic start_req;

  sar_start_merge #(.SYNC_STAGES(2)) u_merge (
    .clk        (clk),
    .rst        (rst),
    .sw_start   (sw_start),
    .tmr_ovf    (tmr_ovf),
    .tmr_en     (tmr_en),
    .ext_trig_n (ext_trig_n),
    .ext_en     (ext_en),
    .start_req  (start_req)
  );

  sar_seq_engine #(
    .NBITS      (NBITS),
    .SETTLE_CYC (SETTLE_CYC),
    .STEP_CYC   (STEP_CYC)
  ) u_engine (
    .clk        (clk),
    .rst        (rst),
    .start_req  (start_req),
    .cmp_ge     (cmp_ge),
    .trial_code (trial_code),
    .hold       (hold),
    .busy       (busy),
    .result     (result),
    .eoc        (eoc),
    .start_err  (start_err)
  );

endmodule

// File: tb/tb_sar_conv_seq.sv
`timescale 1ns/1ps
module tb_sar_conv_seq;

  localparam int S   = 8;   // 40 ns at 200 MHz
  localparam int P   = 4;   // 20 ns at 200 MHz
  localparam int N   = 12;
  localparam int LAT = S + N * P;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sw_start = 1'b0, tmr_ovf = 1'b0, tmr_en = 1'b0;
  logic ext_trig_n = 1'b1, ext_en = 1'b0;
  logic [N-1:0] vin = '0;
  logic cmp_ge;
  logic [N-1:0] trial_code, result;
  logic hold, busy, eoc, start_err;

  int errs = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  // Comparator model: input code at or above trial code
  assign cmp_ge = (vin >= trial_code);

  sar_conv_seq #(
    .CLK_HZ(200_000_000), .SETTLE_NS(40), .STEP_NS(20), .NBITS(N)
  ) dut (
    .clk(clk), .rst(rst), .sw_start(sw_start), .tmr_ovf(tmr_ovf),
    .tmr_en(tmr_en), .ext_trig_n(ext_trig_n), .ext_en(ext_en),
    .cmp_ge(cmp_ge), .trial_code(trial_code), .hold(hold), .busy(busy),
    .result(result), .eoc(eoc), .start_err(start_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // src: 0 software (R1), 1 timer (R2), 2 external (R3)
  // inj: cycle index at which a colliding software start is pulsed (-1 none)
  task automatic run_conv(input int src, input logic [N-1:0] v, input int inj);
    int first_eoc = -1, eoc_cnt = 0, hold_rise = -1, err_cnt = 0, err_at = -1;
    logic [N-1:0] trial_at = '0;
    logic [N-1:0] prev_res;
    logic busy0 = 1'b0;
    logic res_kept = 1'b1;
    string tag;
    tag = (src == 0) ? "R1" : (src == 1) ? "R2" : "R3";
    vin = v;
    prev_res = result;
    @(negedge clk);
    case (src)
      0: sw_start = 1'b1;
      1: begin tmr_en = 1'b1; tmr_ovf = 1'b1; end
      default: begin ext_en = 1'b1; ext_trig_n = 1'b0; end
    endcase
    if (src == 2) repeat (2) @(posedge clk);
    @(posedge clk);  // start edge
    for (int k = 0; k <= LAT + 2; k++) begin
      @(negedge clk);
      if (k == 0) begin sw_start = 1'b0; tmr_ovf = 1'b0; busy0 = busy; end
      if (inj >= 0 && k == inj) sw_start = 1'b1;
      if (inj >= 0 && k == inj + 1) sw_start = 1'b0;
      if (hold && hold_rise < 0) begin hold_rise = k; trial_at = trial_code; end
      if (eoc) begin eoc_cnt++; if (first_eoc < 0) first_eoc = k; end
      if (start_err) begin err_cnt++; if (err_at < 0) err_at = k; end
      if (k < LAT && result != prev_res) res_kept = 1'b0;
      if (k == LAT) begin
        chk(!busy && !hold, "R6 idle at eoc", {busy, hold}, 0);
      end
    end
    chk(busy0 == 1'b1, {tag, " busy after start"}, busy0, 1);
    chk(hold_rise == S, "R4 hold rise cycle", hold_rise, S);
    chk(trial_at == 12'h800, "R4 first trial", trial_at, 12'h800);
    chk(first_eoc == LAT, "R6 eoc cycle", first_eoc, LAT);
    chk(eoc_cnt == 1, "R6 eoc width", eoc_cnt, 1);
    chk(result == v, "R5 result", result, v);
    chk(res_kept, "R8 result held until eoc", res_kept, 1);
    if (inj < 0) chk(err_cnt == 0, "R7 no error when idle", err_cnt, 0);
    else begin
      chk(err_cnt == 1, "R7 error width", err_cnt, 1);
      chk(err_at == inj + 1, "R7 error cycle", err_at, inj + 1);
    end
    ext_trig_n = 1'b1;
    repeat (4) @(negedge clk);
    ext_en = 1'b0;
    tmr_en = 1'b0;
  endtask

  // Observe that nothing starts for a window of cycles
  task automatic expect_idle(input string req, input int cycles);
    int seen = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (busy || hold || eoc) seen++;
    end
    chk(seen == 0, req, seen, 0);
  endtask

  // {source, input code}
  localparam logic [13:0] VECS [8] = '{
    {2'd0, 12'h000}, {2'd0, 12'hFFF}, {2'd1, 12'h800}, {2'd2, 12'h7FF},
    {2'd0, 12'h555}, {2'd1, 12'hAAA}, {2'd2, 12'h001}, {2'd0, 12'h123}
  };

  initial begin
    #(200000 * 5);
    errs++; checks++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk({busy, hold, eoc, start_err} == 4'b0, "R9 flags after reset", {busy, hold, eoc, start_err}, 0);
    chk(trial_code == '0, "R9 trial after reset", trial_code, 0);
    chk(result == '0, "R9 result after reset", result, 0);

    for (int i = 0; i < 8; i++) run_conv(int'(VECS[i][13:12]), VECS[i][11:0], -1);

    // R2: overflow pulse with its enable low
    @(negedge clk) begin tmr_en = 1'b0; tmr_ovf = 1'b1; end
    @(negedge clk) tmr_ovf = 1'b0;
    expect_idle("R2 disabled overflow", 8);

    // R3: falling edge while disabled, then rising edge while enabled
    @(negedge clk) begin ext_en = 1'b0; ext_trig_n = 1'b0; end
    expect_idle("R3 disabled falling edge", 8);
    @(negedge clk) begin ext_en = 1'b1; ext_trig_n = 1'b1; end
    expect_idle("R3 rising edge", 8);
    @(negedge clk) ext_en = 1'b0;

    // R7: collision during settle, then during the search
    run_conv(0, 12'h3C5, 3);
    run_conv(1, 12'hC3A, 25);
    // R7: collision coinciding with final-step edge is still reported
    run_conv(2, 12'h801, LAT - 1);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule